// File: doc/BRIEF.md
# Boot ROM Address Decoder with Interrupt Vector Redirect

This block turns each 16-bit processor bus address into one of four mutually exclusive selects: the on-chip boot ROM at the top of memory, the on-chip RAM at the bottom, external program memory for everything in between, and a null select for a vector slot that has no handler. It also delivers the address that the selected memory should see. While the boot ROM is switched on, reads of the interrupt vector slots at the top of memory are redirected into a small table near the top of internal RAM. A program downloaded into RAM can therefore supply its own interrupt handlers while the boot code still owns the real vector addresses.

A single control bit, held in the block and written by software, turns the boot ROM off. From the next cycle the top 512 bytes of the map fall through to external memory, and no vector redirect takes place. While the boot ROM is on, writes into the RAM span that the boot code keeps for its own use raise a warning flag. All outputs are registered, so each decode appears one clock after the bus cycle is presented.

Top module: `boot_addr_decoder`

## Requirements
- R1: On synchronous active-high reset all selects, `unimpl_vec_o` and `guard_hit_o` are low, and the boot ROM control bit resets to 1 (boot ROM on).
- R2: In a cycle with neither `rd_i` nor `wr_i` high, the four selects and both flags are low one clock later.
- R3: In a cycle with `rd_i` or `wr_i` high, exactly one of `sel_rom_o`, `sel_ram_o`, `sel_ext_o`, `sel_null_o` is high one clock later, together with that cycle's decode on `mem_addr_o`.
- R4: With the boot ROM on, any access to 0xFE00–0xFFFF that is not a redirected or null vector read selects the ROM, and `mem_addr_o` equals the input address.
- R5: With the boot ROM on, a read (with `wr_i` low) of 0xFFEE–0xFFFB or 0xFFFE–0xFFFF selects RAM, and `mem_addr_o` is the input with bits 15:12 cleared (0xFFEE gives 0x0FEE, 0xFFFE gives 0x0FFE).
- R6: With the boot ROM on, a read of 0xFFFC or 0xFFFD selects `sel_null_o` and raises `unimpl_vec_o`; the address passes unchanged.
- R7: Addresses 0x0000–0x0FFF select RAM, and 0x1000–0xFDFF (including the application start at 0x1800) select external memory, address unchanged, regardless of the control bit.
- R8: When `boot_we_i` is high at a clock edge, the control bit takes `boot_d_i`. With the bit at 0, accesses from the following cycle to 0xFE00–0xFFFF select external memory with the address unchanged and never raise `unimpl_vec_o`. Writing 1 turns the boot ROM on again.
- R9: A write to 0x0080–0x00FF while the boot ROM is on raises `guard_hit_o` with the RAM select. Reads there, writes outside that span, and any write with the boot ROM off leave it low.
- R10: A cycle with both `rd_i` and `wr_i` high is decoded as a write, so a vector address then selects the ROM and is not redirected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | Processor address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| boot_we_i | input | 1 | Write enable for the boot ROM control bit |
| boot_d_i | input | 1 | New value of the boot ROM control bit |
| sel_rom_o | output | 1 | Boot ROM select |
| sel_ram_o | output | 1 | Internal RAM select |
| sel_ext_o | output | 1 | External memory select |
| sel_null_o | output | 1 | Null select for an unimplemented vector slot |
| mem_addr_o | output | 16 | Address presented to the selected memory |
| unimpl_vec_o | output | 1 | Read of the vector slot that has no handler |
| guard_hit_o | output | 1 | Write into the RAM span kept for the boot code |

## Verification
The hardest case is the change of the control bit, because the redirect, the null slot and the guard flag all depend on a state that only shows up in later decodes. The stimulus writes the bit to 0 and then repeats the vector reads and guarded writes that were checked with the bit at 1, including the null slot. It then writes the bit back to 1 and checks that the redirect returns. Addresses on both sides of each window edge (0xFFED/0xFFEE, 0xFFFB/0xFFFC, 0x007F/0x0080, 0x00FF/0x0100, 0x0FFF/0x1000, 0xFDFF/0xFE00) pin down the comparators, and a cycle with both strobes high separates the read-only redirect from the write path.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_EXT  = 2'd1,
    RGN_ROM  = 2'd2,
    RGN_NULL = 2'd3
  } region_e;

  typedef struct packed {
    logic        valid;
    region_e     region;
    logic [15:0] addr;
    logic        unimpl;
    logic        guard;
  } decode_s;

endpackage

// File: rtl/bdec_ctrl_bit.sv
module bdec_ctrl_bit #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= d;
  end

endmodule

// File: rtl/bdec_vec_match.sv
module bdec_vec_match #(
  parameter int          AW        = 16,
  parameter logic [15:0] VEC_LO    = 16'hFFEE,
  parameter int          NSLOT     = 9,
  parameter logic [8:0]  IMPL_MASK = 9'h17F
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic          impl
);

  localparam logic [AW-2:0] SBASE = VEC_LO[AW-1:1];

  logic [NSLOT-1:0] slot_hit;

  // One two-byte slot per comparator, laid out upward from VEC_LO.
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [AW-2:0] SLOT_W = SBASE + (AW-1)'(k);
    assign slot_hit[k] = (addr[AW-1:1] == SLOT_W);
  end

  assign hit  = |slot_hit;
  assign impl = |(slot_hit & IMPL_MASK[NSLOT-1:0]);

endmodule

// File: rtl/bdec_region.sv
module bdec_region
  import boot_dec_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [15:0] ROM_BASE  = 16'hFE00,
  parameter logic [15:0] RAM_TOP   = 16'h0FFF,
  parameter logic [15:0] GUARD_LO  = 16'h0080,
  parameter logic [15:0] GUARD_HI  = 16'h00FF,
  parameter int          CLR_BITS  = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          rom_on,
  input  logic          vec_hit,
  input  logic          vec_impl,
  output decode_s       dec
);

  localparam logic [AW-1:0] KEEP_MASK = {AW{1'b1}} >> CLR_BITS;

  logic in_rom, in_ram, in_guard, is_read;

  assign in_rom   = (addr >= ROM_BASE[AW-1:0]);
  assign in_ram   = (addr <= RAM_TOP[AW-1:0]);
  assign in_guard = (addr >= GUARD_LO[AW-1:0]) && (addr <= GUARD_HI[AW-1:0]);
  assign is_read  = rd && !wr;

  always_comb begin
    dec        = '0;
    dec.valid  = rd || wr;
    dec.region = RGN_EXT;
    dec.addr   = 16'(addr);
    if (rom_on && in_rom) begin
      if (is_read && vec_hit && vec_impl) begin
        dec.region = RGN_RAM;
        dec.addr   = 16'(addr & KEEP_MASK);
      end else if (is_read && vec_hit) begin
        dec.region = RGN_NULL;
        dec.unimpl = dec.valid;
      end else begin
        dec.region = RGN_ROM;
      end
    end else if (in_ram) begin
      dec.region = RGN_RAM;
      dec.guard  = wr && rom_on && in_guard;
    end
  end

endmodule

// File: rtl/boot_addr_decoder.sv
module boot_addr_decoder
  import boot_dec_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [15:0] ROM_BASE  = 16'hFE00,
  parameter logic [15:0] RAM_TOP   = 16'h0FFF,
  parameter logic [15:0] VEC_LO    = 16'hFFEE,
  parameter int          NSLOT     = 9,
  parameter logic [8:0]  IMPL_MASK = 9'h17F,
  parameter logic [15:0] GUARD_LO  = 16'h0080,
  parameter logic [15:0] GUARD_HI  = 16'h00FF,
  parameter int          CLR_BITS  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          boot_we_i,
  input  logic          boot_d_i,
  output logic          sel_rom_o,
  output logic          sel_ram_o,
  output logic          sel_ext_o,
  output logic          sel_null_o,
  output logic [15:0]   mem_addr_o,
  output logic          unimpl_vec_o,
  output logic          guard_hit_o
);

  logic    rom_on;
  logic    vec_hit, vec_impl;
  decode_s dec;

  bdec_ctrl_bit #(.RST_VAL(1'b1)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .we  (boot_we_i),
    .d   (boot_d_i),
    .q   (rom_on)
  );

  bdec_vec_match #(
    .AW(AW), .VEC_LO(VEC_LO), .NSLOT(NSLOT), .IMPL_MASK(IMPL_MASK)
  ) u_vec (
    .addr (addr_i[AW-1:0]),
    .hit  (vec_hit),
    .impl (vec_impl)
  );

  bdec_region #(
    .AW(AW), .ROM_BASE(ROM_BASE), .RAM_TOP(RAM_TOP),
    .GUARD_LO(GUARD_LO), .GUARD_HI(GUARD_HI), .CLR_BITS(CLR_BITS)
  ) u_rgn (
    .addr     (addr_i[AW-1:0]),
    .rd       (rd_i),
    .wr       (wr_i),
    .rom_on   (rom_on),
    .vec_hit  (vec_hit),
    .vec_impl (vec_impl),
    .dec      (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_rom_o    <= 1'b0;
      sel_ram_o    <= 1'b0;
      sel_ext_o    <= 1'b0;
      sel_null_o   <= 1'b0;
      mem_addr_o   <= '0;
      unimpl_vec_o <= 1'b0;
      guard_hit_o  <= 1'b0;
    end else begin
      sel_rom_o    <= dec.valid && (dec.region == RGN_ROM);
      sel_ram_o    <= dec.valid && (dec.region == RGN_RAM);
      sel_ext_o    <= dec.valid && (dec.region == RGN_EXT);
      sel_null_o   <= dec.valid && (dec.region == RGN_NULL);
      mem_addr_o   <= dec.addr;
      unimpl_vec_o <= dec.unimpl;
      guard_hit_o  <= dec.guard;
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_i || wr_i)) |->
      ($countones({sel_rom_o, sel_ram_o, sel_ext_o, sel_null_o}) == 1)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_i || wr_i)) |->
      !(sel_rom_o || sel_ram_o || sel_ext_o || sel_null_o || guard_hit_o)); // R2

  AST_ROM_OFF_NO_ROM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rom_on)) |-> !sel_rom_o && !sel_null_o); // R8

  AST_EXT_ADDR_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sel_ext_o) |-> (mem_addr_o == $past(addr_i))); // R7

  AST_GUARD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    guard_hit_o |-> ($past(wr_i) && sel_ram_o)); // R9

  AST_UNIMPL_NULL: assert property (@(posedge clk) disable iff (rst)
    unimpl_vec_o |-> (sel_null_o && !$past(wr_i))); // R6

endmodule

// File: tb/sim_boot_addr_decoder.sv
module sim_boot_addr_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0, boot_we_i = 1'b0, boot_d_i = 1'b0;
  logic        sel_rom_o, sel_ram_o, sel_ext_o, sel_null_o;
  logic [15:0] mem_addr_o;
  logic        unimpl_vec_o, guard_hit_o;

  int checks = 0;
  int failures = 0;

  // select codes {null, ext, ram, rom}
  localparam logic [3:0] S_NONE = 4'b0000, S_ROM = 4'b0001, S_RAM = 4'b0010,
                         S_EXT = 4'b0100, S_NUL = 4'b1000;

  always #10 clk = ~clk;

  boot_addr_decoder u0 (.*);

  task automatic check(string req, logic [21:0] act, logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one bus cycle, then compare the registered result one clock later.
  task automatic cyc(string req, logic [15:0] a, logic r, logic w,
                     logic [3:0] es, logic [15:0] ea, logic eu, logic eg);
    @(negedge clk);
    addr_i = a; rd_i = r; wr_i = w;
    @(posedge clk); #1;
    check(req, {sel_null_o, sel_ext_o, sel_ram_o, sel_rom_o, mem_addr_o, unimpl_vec_o, guard_hit_o},
          {es, ea, eu, eg});
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic set_boot(logic v);
    @(negedge clk);
    boot_we_i = 1'b1; boot_d_i = v;
    @(negedge clk);
    boot_we_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs",
          {sel_null_o, sel_ext_o, sel_ram_o, sel_rom_o, unimpl_vec_o, guard_hit_o}, 22'h0);
    @(negedge clk); rst = 1'b0;
    cyc("R1 boot ROM on after reset", 16'hFFF0, 1, 0, S_RAM, 16'h0FF0, 0, 0);
  endtask

  task automatic t_idle();
    cyc("R2 idle vector addr", 16'hFFFE, 0, 0, S_NONE, 16'hFFFE, 0, 0);
    cyc("R2 idle guard addr", 16'h0090, 0, 0, S_NONE, 16'h0090, 0, 0);
  endtask

  task automatic t_plain_map();
    cyc("R7 app start ext", 16'h1800, 1, 0, S_EXT, 16'h1800, 0, 0);
    cyc("R7 ram low", 16'h0005, 1, 0, S_RAM, 16'h0005, 0, 0);
    cyc("R7 ram top", 16'h0FFF, 0, 1, S_RAM, 16'h0FFF, 0, 0);
    cyc("R7 ext bottom", 16'h1000, 1, 0, S_EXT, 16'h1000, 0, 0);
    cyc("R7 ext top", 16'hFDFF, 1, 0, S_EXT, 16'hFDFF, 0, 0);
  endtask

  task automatic t_rom();
    cyc("R4 rom base", 16'hFE00, 1, 0, S_ROM, 16'hFE00, 0, 0);
    cyc("R4 below trap slot", 16'hFFED, 1, 0, S_ROM, 16'hFFED, 0, 0);
    cyc("R4 write vector slot", 16'hFFF0, 0, 1, S_ROM, 16'hFFF0, 0, 0);
  endtask

  task automatic t_vectors();
    cyc("R5 trap", 16'hFFEE, 1, 0, S_RAM, 16'h0FEE, 0, 0);
    cyc("R5 reset vec", 16'hFFFE, 1, 0, S_RAM, 16'h0FFE, 0, 0);
    cyc("R5 reset vec low byte", 16'hFFFF, 1, 0, S_RAM, 16'h0FFF, 0, 0);
    cyc("R5 sci odd byte", 16'hFFF1, 1, 0, S_RAM, 16'h0FF1, 0, 0);
    cyc("R5 swi odd byte", 16'hFFFB, 1, 0, S_RAM, 16'h0FFB, 0, 0);
  endtask

  task automatic t_null();
    cyc("R6 null slot", 16'hFFFC, 1, 0, S_NUL, 16'hFFFC, 1, 0);
    cyc("R6 null slot odd", 16'hFFFD, 1, 0, S_NUL, 16'hFFFD, 1, 0);
  endtask

  task automatic t_guard();
    cyc("R9 guard low edge", 16'h0080, 0, 1, S_RAM, 16'h0080, 0, 1);
    cyc("R9 guard high edge", 16'h00FF, 0, 1, S_RAM, 16'h00FF, 0, 1);
    cyc("R9 above guard", 16'h0100, 0, 1, S_RAM, 16'h0100, 0, 0);
    cyc("R9 below guard", 16'h007F, 0, 1, S_RAM, 16'h007F, 0, 0);
    cyc("R9 read in guard", 16'h0080, 1, 0, S_RAM, 16'h0080, 0, 0);
  endtask

  task automatic t_both_strobes();
    cyc("R10 rd+wr vector", 16'hFFF0, 1, 1, S_ROM, 16'hFFF0, 0, 0);
    cyc("R10 rd+wr null slot", 16'hFFFC, 1, 1, S_ROM, 16'hFFFC, 0, 0);
  endtask

  task automatic t_boot_off();
    set_boot(1'b0);
    cyc("R8 off reset vec", 16'hFFFE, 1, 0, S_EXT, 16'hFFFE, 0, 0);
    cyc("R8 off null slot", 16'hFFFC, 1, 0, S_EXT, 16'hFFFC, 0, 0);
    cyc("R8 off rom base", 16'hFE00, 1, 0, S_EXT, 16'hFE00, 0, 0);
    cyc("R8 off guard write", 16'h0080, 0, 1, S_RAM, 16'h0080, 0, 0);
    cyc("R8 off ram read", 16'h0FF0, 1, 0, S_RAM, 16'h0FF0, 0, 0);
    set_boot(1'b1);
    cyc("R8 on again vector", 16'hFFF0, 1, 0, S_RAM, 16'h0FF0, 0, 0);
    cyc("R8 on again guard", 16'h00C0, 0, 1, S_RAM, 16'h00C0, 0, 1);
  endtask

  task automatic t_onehot_sweep();
    // R3: one select for a spread of addresses, reads and writes
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      addr_i = 16'(i * 1031 + 16'hFC00 * (i % 2));
      rd_i = (i % 3) != 0; wr_i = (i % 3) == 0;
      @(posedge clk); #1;
      check("R3 exactly one select",
            22'($countones({sel_null_o, sel_ext_o, sel_ram_o, sel_rom_o})), 22'd1);
      rd_i = 1'b0; wr_i = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_plain_map();
    t_rom();
    t_vectors();
    t_null();
    t_guard();
    t_both_strobes();
    t_boot_off();
    t_onehot_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule